// File: doc/BRIEF.md
# SPI Ferroelectric RAM Target

This block is an SPI slave, clock mode 0, that behaves like a byte-addressed nonvolatile RAM. It answers the command set of a serial flash. There is no erase and no busy state, because every write finishes while the bus is still clocking. A host selects the block, sends a one-byte opcode and, for the memory commands, a big-endian address of `ADDR_BYTES` bytes. It then shifts data in or out for as long as chip select stays low. The address advances by one after every data byte.

The SPI pins are sampled by the system clock through two-stage synchronizers, so the serial clock must run well below `clk`. Storage is an internal synchronous array of `MEM_DEPTH` bytes. A write-enable latch gates both write commands. A small status byte reports that latch and holds four general-purpose bits that the host can write. An identification command returns a three-byte code whose density byte is a parameter.

Top module: `fram_spi_target`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it; the latch is set by nothing else.
- R2: Opcode 0x05 streams the status byte for as long as clocks continue: bit 1 is the write-enable latch; bits 7, 6, 3 and 2 hold the last accepted status write; bits 5, 4 and 0 always read 0.
- R3: Opcode 0x01 followed by a byte copies that byte's bits 7, 6, 3 and 2 into the status byte, only when the latch is set.
- R4: After opcode 0x03 or 0x02 the next `ADDR_BYTES` bytes form the start address, most significant byte first.
- R5: Opcode 0x03 returns memory bytes from the start address, one per byte time, with the address incrementing after each byte and wrapping from `MEM_DEPTH`-1 to 0; address bits above the memory index are ignored.
- R6: Opcode 0x02 stores each following byte at consecutive addresses when the latch is set; with the latch clear, memory is left unchanged.
- R7: The latch clears when chip select rises at the end of a 0x02 or 0x01 frame, and a final data bit whose clock edge coincides with that rise is still stored.
- R8: Opcode 0x9F returns 0xC2, then `DENSITY_CODE` (default 0x22), then `REV_CODE` (default 0x00), then 0x00 for every later byte.
- R9: Any other opcode makes the block ignore the rest of the frame: no memory, latch or status change, and `spi_miso_oe` stays low until chip select rises.
- R10: MISO changes after falling clock edges, the first data bit is valid before the first rising edge of the data phase, and `spi_miso_oe` is high only during the data phase of 0x03, 0x05 and 0x9F.
- R11: After reset the latch and the status byte are 0 and `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select; its rise ends a frame |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, MSB first |
| spi_miso_oe | output | 1 | High while the block drives `spi_miso` |

## Verification
The last data bit of a write frame can reach the block in the same system cycle as the chip-select rise that clears the write-enable latch. The store must still use the latch value from before the clear. The bench provokes this by raising the serial clock and chip select together on the final bit. It then reads the address back and expects the new byte, and reads the status and expects the latch bit to be clear.

// File: rtl/fram_spi_target.sv
module fram_spi_target #(
  parameter int          ADDR_BYTES   = 2,
  parameter int          MEM_DEPTH    = 4096,
  parameter logic [7:0]  DENSITY_CODE = 8'h22,
  parameter logic [7:0]  REV_CODE     = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);

  localparam int IW = $clog2(MEM_DEPTH);
  localparam logic [1:0] LAST_ADR = 2'(ADDR_BYTES - 1);

  typedef enum logic [1:0] {PH_OP, PH_ADR, PH_DAT, PH_IGN} phase_t;
  typedef enum logic [2:0] {C_NONE, C_RD, C_WR, C_RDSR, C_WRSR, C_ID} cmd_t;

  logic [2:0] sck_q;
  logic [2:0] cs_q;
  logic [1:0] mosi_q;
  phase_t     phase;
  cmd_t       cmd;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [1:0] adr_cnt;
  logic [IW-1:0] adr;
  logic [1:0] id_idx;
  logic [7:0] tx_sh;
  logic       wel;
  logic [3:0] sr_keep;
  logic [7:0] rd_q;
  logic [7:0] mem [MEM_DEPTH];

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire in_frame = ~cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire mosi_b   = mosi_q[1];

  wire       byte_done = in_frame && sck_rise && (bit_cnt == 3'd7);
  wire [7:0] rx_byte   = {rx_sh, mosi_b};
  wire [7:0] status    = {sr_keep[3:2], 2'b00, sr_keep[1:0], wel, 1'b0};

  wire op_hit   = byte_done && (phase == PH_OP);
  wire wren_hit = op_hit && (rx_byte == 8'h06);
  wire wrdi_hit = op_hit && (rx_byte == 8'h04);
  wire mem_we   = byte_done && (phase == PH_DAT) && (cmd == C_WR) && wel;
  wire sr_we    = byte_done && (phase == PH_DAT) && (cmd == C_WRSR) && wel;
  wire tx_load  = in_frame && sck_fall && (bit_cnt == 3'd0) && (phase == PH_DAT);

  logic [7:0] id_byte;
  always_comb begin
    case (id_idx)
      2'd0:    id_byte = 8'hC2;
      2'd1:    id_byte = DENSITY_CODE;
      2'd2:    id_byte = REV_CODE;
      default: id_byte = 8'h00;
    endcase
  end

  assign spi_miso    = tx_sh[7];
  assign spi_miso_oe = in_frame && (phase == PH_DAT) &&
                       (cmd == C_RD || cmd == C_RDSR || cmd == C_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 3'b000;
      cs_q   <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_OP;
      cmd     <= C_NONE;
      bit_cnt <= 3'd0;
      rx_sh   <= 7'd0;
      adr_cnt <= 2'd0;
      adr     <= '0;
      id_idx  <= 2'd0;
      tx_sh   <= 8'd0;
    end else if (!in_frame) begin
      phase   <= PH_OP;
      cmd     <= C_NONE;
      bit_cnt <= 3'd0;
      adr_cnt <= 2'd0;
      id_idx  <= 2'd0;
    end else begin
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sh   <= {rx_sh[5:0], mosi_b};
      end
      if (byte_done) begin
        case (phase)
          PH_OP: begin
            case (rx_byte)
              8'h03:   begin cmd <= C_RD;   phase <= PH_ADR; end
              8'h02:   begin cmd <= C_WR;   phase <= PH_ADR; end
              8'h05:   begin cmd <= C_RDSR; phase <= PH_DAT; end
              8'h01:   begin cmd <= C_WRSR; phase <= PH_DAT; end
              8'h9F:   begin cmd <= C_ID;   phase <= PH_DAT; end
              default: begin cmd <= C_NONE; phase <= PH_IGN; end
            endcase
          end
          PH_ADR: begin
            adr     <= IW'({adr, rx_byte});
            adr_cnt <= adr_cnt + 2'd1;
            if (adr_cnt == LAST_ADR) phase <= PH_DAT;
          end
          PH_DAT: begin
            if (mem_we) adr <= adr + 1'b1;
          end
          default: ;
        endcase
      end
      if (tx_load) begin
        case (cmd)
          C_RD: begin
            tx_sh <= rd_q;
            adr   <= adr + 1'b1;
          end
          C_RDSR: tx_sh <= status;
          C_ID: begin
            tx_sh <= id_byte;
            if (id_idx != 2'd3) id_idx <= id_idx + 2'd1;
          end
          default: tx_sh <= 8'd0;
        endcase
      end else if (sck_fall) begin
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel     <= 1'b0;
      sr_keep <= 4'd0;
    end else begin
      if (wren_hit)
        wel <= 1'b1;
      else if (wrdi_hit || (cs_rise && (cmd == C_WR || cmd == C_WRSR)))
        wel <= 1'b0;
      if (sr_we) sr_keep <= {rx_byte[7:6], rx_byte[3:2]};
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[adr] <= rx_byte;
    rd_q <= mem[adr];
  end

  assert_wel_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wren_hit));

  assert_wel_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && (cmd == C_WR || cmd == C_WRSR)) |=> !wel);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (adr == $past(adr) + 1'b1));

  assert_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |-> !spi_miso_oe);

  assert_id_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && cmd == C_ID && id_idx == 2'd0) |=> (tx_sh == 8'hC2));

  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q[2] && cs_q[1]) |-> !spi_miso_oe);

endmodule

// File: tb/test_fram_spi_target.sv
module test_fram_spi_target;

  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso;
  logic spi_miso_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fram_spi_target i_fram_spi_target (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HP) @(posedge clk);
    #2;
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q, inout logic oe_any);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = d[i];
      half();
      q[i] = spi_miso;
      oe_any = oe_any | spi_miso_oe;
      spi_sck = 1'b1;
      half();
      spi_sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    spi_cs_n = 1'b0;
    half();
  endtask

  task automatic cs_hi();
    half();
    spi_cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic op_only(input logic [7:0] op);
    logic [7:0] q;
    logic oe = 1'b0;
    cs_lo();
    xfer(op, q, oe);
    cs_hi();
  endtask

  task automatic status_rd(output logic [7:0] s0, output logic [7:0] s1);
    logic [7:0] q;
    logic oe = 1'b0;
    cs_lo();
    xfer(8'h05, q, oe);
    xfer(8'h00, s0, oe);
    xfer(8'h00, s1, oe);
    cs_hi();
  endtask

  task automatic status_wr(input logic [7:0] v);
    logic [7:0] q;
    logic oe = 1'b0;
    cs_lo();
    xfer(8'h01, q, oe);
    xfer(v, q, oe);
    cs_hi();
  endtask

  task automatic mem_wr(input logic [15:0] a, input int n, input logic [31:0] d);
    logic [7:0] q;
    logic oe = 1'b0;
    cs_lo();
    xfer(8'h02, q, oe);
    xfer(a[15:8], q, oe);
    xfer(a[7:0], q, oe);
    for (int k = 0; k < n; k++) xfer(d[31-8*k -: 8], q, oe);
    cs_hi();
  endtask

  task automatic mem_rd(input logic [15:0] a, input int n, output logic [31:0] d, output logic oe_seen);
    logic [7:0] q;
    logic oe = 1'b0;
    d = 32'd0;
    cs_lo();
    xfer(8'h03, q, oe);
    xfer(a[15:8], q, oe);
    xfer(a[7:0], q, oe);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, q, oe);
      d[31-8*k -: 8] = q;
    end
    oe_seen = spi_miso_oe;
    cs_hi();
  endtask

  task automatic t_reset();
    logic [7:0] s0, s1;
    check("R11 oe after reset", {31'd0, spi_miso_oe}, 32'd0);
    status_rd(s0, s1);
    check("R11 status after reset", {24'd0, s0}, 32'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s0, s1;
    op_only(8'h06);
    status_rd(s0, s1);
    check("R1 latch set", {24'd0, s0}, 32'h02);
    check("R2 status repeats", {24'd0, s1}, 32'h02);
    op_only(8'h04);
    status_rd(s0, s1);
    check("R1 latch cleared", {24'd0, s0}, 32'h00);
  endtask

  task automatic t_status_write();
    logic [7:0] s0, s1;
    op_only(8'h06);
    status_wr(8'hFF);
    status_rd(s0, s1);
    check("R2 R3 R7 writable bits only", {24'd0, s0}, 32'hCC);
    status_wr(8'h00);
    status_rd(s0, s1);
    check("R3 blocked without latch", {24'd0, s0}, 32'hCC);
    op_only(8'h06);
    status_wr(8'h00);
    status_rd(s0, s1);
    check("R3 cleared", {24'd0, s0}, 32'h00);
  endtask

  task automatic t_write_read();
    logic [31:0] d;
    logic [7:0] s0, s1;
    logic oe;
    op_only(8'h06);
    mem_wr(16'h0123, 3, 32'h112233_00);
    status_rd(s0, s1);
    check("R7 latch clear after write", {24'd0, s0}, 32'h00);
    mem_rd(16'h0123, 3, d, oe);
    check("R5 R6 stream", d, 32'h112233_00);
    check("R10 oe during read", {31'd0, oe}, 32'd1);
    mem_rd(16'h0124, 1, d, oe);
    check("R4 address msb first", d, 32'h22_000000);
    mem_wr(16'h0123, 1, 32'hEE_000000);
    mem_rd(16'h0123, 1, d, oe);
    check("R6 write blocked", d, 32'h11_000000);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    logic oe;
    op_only(8'h06);
    mem_wr(16'h0FFF, 2, 32'hA1A2_0000);
    mem_rd(16'h0FFF, 2, d, oe);
    check("R5 wrap", d, 32'hA1A2_0000);
    mem_rd(16'h1000, 1, d, oe);
    check("R5 upper bits ignored", d, 32'hA2_000000);
  endtask

  task automatic t_id();
    logic [7:0] q, b0, b1, b2, b3;
    logic oe = 1'b0;
    cs_lo();
    xfer(8'h9F, q, oe);
    xfer(8'h00, b0, oe);
    xfer(8'h00, b1, oe);
    xfer(8'h00, b2, oe);
    xfer(8'h00, b3, oe);
    cs_hi();
    check("R8 id bytes", {b0, b1, b2, b3}, 32'hC2220000);
    check("R10 oe low after frame", {31'd0, spi_miso_oe}, 32'd0);
  endtask

  task automatic t_unknown();
    logic [7:0] q, s0, s1;
    logic [31:0] d;
    logic oe = 1'b0;
    logic oe2;
    op_only(8'h06);
    cs_lo();
    xfer(8'hAB, q, oe);
    xfer(8'h02, q, oe);
    xfer(8'h01, q, oe);
    xfer(8'h23, q, oe);
    xfer(8'hEE, q, oe);
    cs_hi();
    check("R9 miso released", {31'd0, oe}, 32'd0);
    status_rd(s0, s1);
    check("R9 latch untouched", {24'd0, s0}, 32'h02);
    mem_rd(16'h0123, 1, d, oe2);
    check("R9 memory untouched", d, 32'h11_000000);
    op_only(8'h04);
  endtask

  task automatic t_coincide();
    logic [7:0] q, s0, s1;
    logic [31:0] d;
    logic oe = 1'b0;
    logic oe2;
    op_only(8'h06);
    cs_lo();
    xfer(8'h02, q, oe);
    xfer(8'h02, q, oe);
    xfer(8'h00, q, oe);
    for (int i = 7; i >= 1; i--) begin
      spi_mosi = 1'((8'h5B >> i) & 8'h01);
      half();
      spi_sck = 1'b1;
      half();
      spi_sck = 1'b0;
    end
    spi_mosi = 1'b1;
    half();
    spi_sck = 1'b1;
    spi_cs_n = 1'b1;
    half();
    spi_sck = 1'b0;
    half();
    half();
    mem_rd(16'h0200, 1, d, oe2);
    check("R7 last bit stored at cs rise", d, 32'h5B_000000);
    status_rd(s0, s1);
    check("R7 latch cleared at cs rise", {24'd0, s0}, 32'h00);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    t_reset();
    t_latch();
    t_status_write();
    t_write_read();
    t_wrap();
    t_id();
    t_unknown();
    t_coincide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R11 actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule